// File: doc/BRIEF.md
# Column CDS Counter

One column of a single-slope conversion back end that does correlated double sampling in the digital domain. While a ramp is compared against the column voltage, the block counts clock cycles for as long as the comparator output stays high. It counts down while the reset level is converted and up while the signal level is converted, so the accumulated value is the signal count minus the reset count. Analog offsets and per-column delays cancel in the subtraction.

Each conversion phase has a window counter that caps the count. The count therefore reaches full scale when the comparator never flips. A resolution mode stretches both windows by a fixed factor. For vertical binning, a keep-sum control blocks the per-row clear, so the second row's down/up conversion adds onto the first. A transfer strobe copies the result, clamped to the output range, into an output register. That register holds the value while the next row converts.

Top module: `col_cds_counter`

## Requirements
- R1: After synchronous reset, `code_o` is 0 and the accumulator is 0.
- R2: With `phase_i` = 2'b01 (reset level), each counted cycle subtracts 1 from the accumulator. With `phase_i` = 2'b10 (signal level), each counted cycle adds 1. One row therefore yields signal count minus reset count.
- R3: `clr_i`=1 with `keep_i`=0 sets the accumulator to 0 at the next edge. This holds even when a count would have happened in that same cycle.
- R4: A phase begins on the first cycle that `phase_i` differs from its value in the previous cycle. From there, the phase counts the consecutive cycles in which `cmp_i` is 1. Once `cmp_i` is sampled 0 during the phase, no further count happens until `phase_i` changes, even if `cmp_i` rises again.
- R5: With `hi_res_i`=0, a phase counts on at most its first RST_WIN cycles (reset level) or SIG_WIN cycles (signal level), even if `cmp_i` never falls.
- R6: With `hi_res_i`=1, both window limits are multiplied by HI_SCALE.
- R7: With `keep_i`=1, `clr_i` has no effect, and the next row's conversion adds onto the held sum.
- R8: `xfer_i`=1 loads `code_o` at the next edge with the accumulator value from before that edge. Negative values load as 0, and values above 2^OUT_W-1 load as 2^OUT_W-1.
- R9: Without `xfer_i`, `code_o` keeps its value while further conversions and clears take place.
- R10: With `phase_i` = 2'b00 or 2'b11, the accumulator does not count, whatever `cmp_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparator output; a count is taken while high |
| phase_i | input | 2 | 00 idle, 01 reset level, 10 signal level, 11 idle |
| clr_i | input | 1 | Zero the accumulator at the start of a row |
| keep_i | input | 1 | Keep the sum: block the clear for binned rows |
| hi_res_i | input | 1 | High-resolution mode; windows scaled by HI_SCALE |
| xfer_i | input | 1 | Transfer the clamped result to the output register |
| code_o | output | OUT_W | Latched, clamped conversion result |

## Verification
The checker examines every cycle for the following: the accumulator never moves against the direction of the current phase, and never by more than one step. It holds in idle phases and while the comparator is low. A clear takes effect regardless of counting. The output moves only on a transfer, and a negative sum transfers as zero. Other behaviours show only through the bench's scenarios. These are the exact counts: the window caps in both resolutions, the stop after a comparator fall even when it rises again, sums across binned rows, clamping at the top of the range, and the count total around a clear issued mid-phase.

// File: rtl/cds_pkg.sv
package cds_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_RST  = 2'b01,
        PH_SIG  = 2'b10,
        PH_SPARE = 2'b11
    } phase_e;

    // One count command per cycle: whether to step, and in which direction
    typedef struct packed {
        logic step;
        logic up;
    } step_t;

    function automatic logic phase_counts(phase_e p);
        return (p == PH_RST) || (p == PH_SIG);
    endfunction
endpackage

// File: rtl/cds_window.sv
module cds_window
    import cds_pkg::*;
#(
    parameter int RST_WIN  = 256,
    parameter int SIG_WIN  = 1024,
    parameter int HI_SCALE = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  logic   cmp,
    input  logic   hi_res,
    output step_t  step
);
    localparam int MAX_WIN = SIG_WIN * HI_SCALE;
    localparam int WIN_W   = $clog2(MAX_WIN + 1);
    localparam logic [WIN_W-1:0] L_RST_LO = WIN_W'(RST_WIN);
    localparam logic [WIN_W-1:0] L_RST_HI = WIN_W'(RST_WIN * HI_SCALE);
    localparam logic [WIN_W-1:0] L_SIG_LO = WIN_W'(SIG_WIN);
    localparam logic [WIN_W-1:0] L_SIG_HI = WIN_W'(SIG_WIN * HI_SCALE);

    phase_e           prev_q;
    logic [WIN_W-1:0] win_q;
    logic             stop_q;

    logic             new_ph;
    logic [WIN_W-1:0] win_eff;
    logic             stop_eff;
    logic [WIN_W-1:0] lim;
    logic             open_win;
    logic             active;

    always_comb begin
        new_ph   = (phase != prev_q);
        win_eff  = new_ph ? '0 : win_q;
        stop_eff = new_ph ? 1'b0 : stop_q;
        active   = phase_counts(phase);
        if (phase == PH_RST)      lim = hi_res ? L_RST_HI : L_RST_LO;
        else if (phase == PH_SIG) lim = hi_res ? L_SIG_HI : L_SIG_LO;
        else                      lim = '0;
        open_win  = (win_eff < lim);
        step.step = active && cmp && !stop_eff && open_win;
        step.up   = (phase == PH_SIG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= PH_IDLE;
            win_q  <= '0;
            stop_q <= 1'b0;
        end else begin
            prev_q <= phase;
            win_q  <= open_win ? win_eff + 1'b1 : win_eff;
            stop_q <= stop_eff | (active & ~cmp);
        end
    end
endmodule

// File: rtl/cds_accum.sv
module cds_accum
    import cds_pkg::*;
#(
    parameter int ACC_W = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    keep,
    input  step_t                   step,
    output logic signed [ACC_W-1:0] acc
);
    localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1);

    always_ff @(posedge clk) begin
        if (rst)                acc <= '0;
        else if (clr && !keep)  acc <= '0;
        else if (step.step)     acc <= step.up ? acc + ONE : acc - ONE;
    end
endmodule

// File: rtl/cds_latch.sv
module cds_latch #(
    parameter int ACC_W = 15,
    parameter int OUT_W = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    xfer,
    input  logic signed [ACC_W-1:0] acc,
    output logic [OUT_W-1:0]        code
);
    localparam logic signed [ACC_W-1:0] CEIL = ACC_W'((1 << OUT_W) - 1);

    logic [OUT_W-1:0] clamped;

    always_comb begin
        if (acc < 0)         clamped = '0;
        else if (acc > CEIL) clamped = '1;
        else                 clamped = acc[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)       code <= '0;
        else if (xfer) code <= clamped;
    end
endmodule

// File: rtl/col_cds_counter.sv
module col_cds_counter
    import cds_pkg::*;
#(
    parameter int RST_WIN  = 256,
    parameter int SIG_WIN  = 1024,
    parameter int HI_SCALE = 4,
    parameter int OUT_W    = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_i,
    input  logic [1:0]       phase_i,
    input  logic             clr_i,
    input  logic             keep_i,
    input  logic             hi_res_i,
    input  logic             xfer_i,
    output logic [OUT_W-1:0] code_o
);
    // Two spare bits: sign, and headroom for a two-row full-scale sum
    localparam int ACC_W = OUT_W + 2;

    phase_e                  phase;
    step_t                   step;
    logic signed [ACC_W-1:0] acc_w;

    assign phase = phase_e'(phase_i);

    cds_window #(
        .RST_WIN (RST_WIN),
        .SIG_WIN (SIG_WIN),
        .HI_SCALE(HI_SCALE)
    ) u_win (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .cmp   (cmp_i),
        .hi_res(hi_res_i),
        .step  (step)
    );

    cds_accum #(.ACC_W(ACC_W)) u_acc (
        .clk (clk),
        .rst (rst),
        .clr (clr_i),
        .keep(keep_i),
        .step(step),
        .acc (acc_w)
    );

    cds_latch #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_lat (
        .clk (clk),
        .rst (rst),
        .xfer(xfer_i),
        .acc (acc_w),
        .code(code_o)
    );
endmodule

// File: rtl/col_cds_counter_chk.sv
module col_cds_counter_chk #(
    parameter int ACC_W = 15,
    parameter int OUT_W = 13
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cmp_i,
    input logic [1:0]              phase_i,
    input logic                    clr_i,
    input logic                    keep_i,
    input logic                    xfer_i,
    input logic signed [ACC_W-1:0] acc,
    input logic [OUT_W-1:0]        code_o
);
    logic wipe;
    assign wipe = clr_i && !keep_i;

    a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (acc == 0));

    a_r2_down_in_reset: assert property (@(posedge clk) disable iff (rst)
        (phase_i == 2'b01 && !wipe) |=> (acc == $past(acc) || acc == $past(acc) - 1));

    a_r2_up_in_signal: assert property (@(posedge clk) disable iff (rst)
        (phase_i == 2'b10 && !wipe) |=> (acc == $past(acc) || acc == $past(acc) + 1));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        ((phase_i == 2'b00 || phase_i == 2'b11) && !wipe) |=> $stable(acc));

    a_r4_cmp_low_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmp_i && !wipe) |=> $stable(acc));

    a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
        !xfer_i |=> $stable(code_o));

    a_r8_neg_clamp: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && acc < 0) |=> (code_o == 0));
endmodule

bind col_cds_counter col_cds_counter_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cmp_i  (cmp_i),
    .phase_i(phase_i),
    .clr_i  (clr_i),
    .keep_i (keep_i),
    .xfer_i (xfer_i),
    .acc    (acc_w),
    .code_o (code_o)
);

// File: tb/sim_col_cds_counter.sv
module sim_col_cds_counter;
    localparam int RW = 4;
    localparam int SW = 16;
    localparam int SC = 4;
    localparam int OW = 7;
    localparam int TOP = (1 << OW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmp = 1'b0;
    logic [1:0]    phase = 2'b00;
    logic          clr = 1'b0;
    logic          keep = 1'b0;
    logic          hi = 1'b0;
    logic          xfer = 1'b0;
    logic [OW-1:0] code;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    col_cds_counter #(.RST_WIN(RW), .SIG_WIN(SW), .HI_SCALE(SC), .OUT_W(OW)) u0 (
        .clk(clk), .rst(rst), .cmp_i(cmp), .phase_i(phase), .clr_i(clr),
        .keep_i(keep), .hi_res_i(hi), .xfer_i(xfer), .code_o(code)
    );

    function automatic int clampv(int v);
        if (v < 0) return 0;
        if (v > TOP) return TOP;
        return v;
    endfunction

    function automatic int capv(int n, int lim);
        return (n < lim) ? n : lim;
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic run_phase(logic [1:0] ph, int nhigh, int len);
        for (int i = 0; i < len; i++) begin
            phase = ph;
            cmp = (i < nhigh);
            @(negedge clk);
        end
        phase = 2'b00;
        cmp = 1'b0;
    endtask

    task automatic row(int r, int s);
        int sc;
        sc = hi ? SC : 1;
        run_phase(2'b01, r, RW * sc + 2);
        run_phase(2'b10, s, SW * sc + 2);
    endtask

    task automatic wipe();
        clr = 1'b1; keep = 1'b0;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic latch();
        xfer = 1'b1;
        @(negedge clk);
        xfer = 1'b0;
    endtask

    function automatic int row_val(int r, int s, bit h);
        int sc;
        sc = h ? SC : 1;
        return capv(s, SW * sc) - capv(r, RW * sc);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset code", int'(code), 0);

        // R2 R5 R8: sweep of 10-bit mode, counts beyond the windows included
        hi = 1'b0;
        for (int r = 0; r <= RW + 1; r++) begin
            for (int s = 0; s <= SW + 1; s++) begin
                wipe();
                row(r, s);
                latch();
                check($sformatf("R2/R5/R8 lo r=%0d s=%0d", r, s), int'(code), clampv(row_val(r, s, 0)));
            end
        end

        // R6: high-resolution windows
        hi = 1'b1;
        for (int r = 0; r <= 20; r += 5) begin
            for (int s = 0; s <= 70; s += 14) begin
                wipe();
                row(r, s);
                latch();
                check($sformatf("R6 hi r=%0d s=%0d", r, s), int'(code), clampv(row_val(r, s, 1)));
            end
        end
        hi = 1'b0;

        // R4: comparator falls then rises again inside the signal phase
        wipe();
        for (int i = 0; i < SW + 2; i++) begin
            phase = 2'b10;
            cmp = (i < 3) || (i >= 5 && i < 10);
            @(negedge clk);
        end
        phase = 2'b00; cmp = 1'b0;
        latch();
        check("R4 stop after comparator fall", int'(code), 3);

        // R3: clear in the middle of an active count
        wipe();
        for (int i = 0; i < SW + 2; i++) begin
            phase = 2'b10;
            cmp = 1'b1;
            clr = (i == 5);
            @(negedge clk);
        end
        phase = 2'b00; cmp = 1'b0; clr = 1'b0;
        latch();
        check("R3 clear beats count", int'(code), 10);

        // R10: idle encodings do not count
        wipe();
        row(0, 5);
        run_phase(2'b00, 12, 12);
        run_phase(2'b11, 12, 12);
        latch();
        check("R10 idle phases ignored", int'(code), 5);

        // R7: binning sums with clr blocked by keep
        begin
            int cases [4][5] = '{'{2, 10, 1, 7, 0}, '{0, 64, 0, 64, 1},
                                 '{4, 0, 4, 0, 0}, '{16, 64, 3, 30, 1}};
            for (int k = 0; k < 4; k++) begin
                hi = cases[k][4][0];
                wipe();
                row(cases[k][0], cases[k][1]);
                clr = 1'b1; keep = 1'b1;
                @(negedge clk);
                clr = 1'b0; keep = 1'b0;
                row(cases[k][2], cases[k][3]);
                latch();
                check($sformatf("R7 binned case %0d", k), int'(code),
                      clampv(row_val(cases[k][0], cases[k][1], hi) +
                             row_val(cases[k][2], cases[k][3], hi)));
            end
            hi = 1'b0;
        end

        // R9: output holds while the next row converts
        wipe();
        row(1, 9);
        latch();
        held = int'(code);
        check("R9 first row latched", held, 8);
        wipe();
        row(0, 14);
        check("R9 output held during next row", int'(code), held);
        latch();
        check("R9 second row latched", int'(code), 14);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule